// File: doc/BRIEF.md
# Packed Word Clip Unit

This block clamps each 32-bit lane of a packed source word into a range set by a 5-bit bound position `n`. The source is XLEN bits wide, with XLEN set to 32 or 64, so there are one or two lanes. Every lane is computed on its own, and all lanes use the same bound and the same operation select.

There are two variants. The signed variant limits a lane to the range from -2^n to 2^n-1. The unsigned variant limits a lane to the range from 0 to 2^n-1. A negative input to the unsigned variant is forced to zero.

The packed result is registered and appears one cycle after the input strobe, together with an output-valid pulse. A sticky saturation flag records that at least one lane was changed by a clip. The flag holds its value until a dedicated clear input is asserted.

Top module: `pw_clip`

## Requirements
- R1: Lane k occupies bits [32k+31:32k] of both source and result, with XLEN/32 lanes. A lane's result depends only on that lane's source bits, `imm_i` and `op_i`.
- R2: When `op_i`=0 (signed), a lane whose value as a two's-complement number is above 2^n-1 becomes 2^n-1. A lane below -2^n becomes -2^n. Here n is `imm_i`.
- R3: When `op_i`=1 (unsigned), a lane whose bit 31 is set becomes zero, and the saturation flag is set.
- R4: When `op_i`=1, a non-negative lane above 2^n-1 becomes 2^n-1.
- R5: A lane inside its range passes through unchanged and does not set the flag. With `op_i`=0 and `imm_i`=31, no lane ever clips.
- R6: When `valid_i` is high at a clock edge, `result_o` and `valid_o`=1 appear after that edge. When `valid_i` is low, `valid_o` is 0 after the edge and `result_o` keeps its value.
- R7: `sat_o` rises after any edge where `valid_i` is high and at least one lane clips. It then stays high until it is cleared.
- R8: When `sat_clr_i` is high at an edge, `sat_o` becomes 0 after that edge. The exception is when a clipping operation is accepted at the same edge: setting has priority, and `sat_o` stays 1.
- R9: While `rst_ni` is low, `result_o`, `valid_o` and `sat_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 1 | 0 = signed clip, 1 = unsigned clip |
| imm_i | input | 5 | Bound position n |
| src_i | input | XLEN | Packed source lanes |
| sat_clr_i | input | 1 | Clears the sticky flag |
| result_o | output | XLEN | Registered packed result |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The hardest values to reach are those exactly on a bound: 2^n-1 and 2^n, and -2^n and -2^n-1. Uniformly random 32-bit operands almost never land on these values for small n. For that reason, the stimulus sweeps all 32 bound positions and builds each lane as a bound value plus a small random offset. A second hard case is a clear arriving at the same edge as a clipping operation. A directed sequence first sets the flag, then idles, then clears with no operation, then issues a clip and a clear together.

// File: rtl/pw_clip_pkg.sv
package pw_clip_pkg;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned IMM_W  = 5;

  typedef enum logic {
    CLIP_SIGNED   = 1'b0,
    CLIP_UNSIGNED = 1'b1
  } clip_op_e;
endpackage

// File: rtl/pw_clip_lane.sv
module pw_clip_lane
  import pw_clip_pkg::*;
#(
  parameter int unsigned W   = LANE_W,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   x_i,
  input  logic [SHW-1:0] n_i,
  input  clip_op_e       op_i,
  output logic [W-1:0]   y_o,
  output logic           clip_o
);
  logic signed [W-1:0] ashr;
  logic [W-1:0]        upper;
  logic [W-1:0]        mag;
  logic                neg;

  always_comb begin
    neg   = x_i[W-1];
    ashr  = $signed(x_i) >>> n_i;
    upper = x_i >> n_i;
    mag   = (W'(1) << n_i) - W'(1);
    y_o    = x_i;
    clip_o = 1'b0;
    if (op_i == CLIP_UNSIGNED) begin
      if (neg) begin
        y_o    = '0;
        clip_o = 1'b1;
      end else if (upper != '0) begin
        y_o    = mag;
        clip_o = 1'b1;
      end
    end else begin
      // in range iff bits above n are pure sign extension
      if (ashr != '0 && ashr != '1) begin
        y_o    = neg ? ~mag : mag;
        clip_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pw_clip_sticky.sv
module pw_clip_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pw_clip.sv
module pw_clip
  import pw_clip_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            op_i,
  input  logic [4:0]      imm_i,
  input  logic [XLEN-1:0] src_i,
  input  logic            sat_clr_i,
  output logic [XLEN-1:0] result_o,
  output logic            valid_o,
  output logic            sat_o
);
  localparam int unsigned NLANE = XLEN / LANE_W;

  logic [XLEN-1:0]  lane_res;
  logic [NLANE-1:0] lane_clip;
  logic             any_clip;
  logic [XLEN-1:0]  res_q;
  logic             vld_q;
  clip_op_e         op_sel;

  assign op_sel = clip_op_e'(op_i);

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    pw_clip_lane #(.W(LANE_W), .SHW(IMM_W)) u_lane (
      .x_i   (src_i[k*LANE_W +: LANE_W]),
      .n_i   (imm_i),
      .op_i  (op_sel),
      .y_o   (lane_res[k*LANE_W +: LANE_W]),
      .clip_o(lane_clip[k])
    );
  end

  assign any_clip = |lane_clip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) res_q <= lane_res;
    end
  end

  pw_clip_sticky u_sat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (valid_i & any_clip),
    .clr_i (sat_clr_i),
    .flag_o(sat_o)
  );

  assign result_o = res_q;
  assign valid_o  = vld_q;
endmodule

// File: rtl/pw_clip_chk.sv
module pw_clip_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic            op_i,
  input logic [4:0]      imm_i,
  input logic [XLEN-1:0] src_i,
  input logic            sat_clr_i,
  input logic [XLEN-1:0] result_o,
  input logic            valid_o,
  input logic            sat_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R6
  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R6
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));  // R6
  AST_SAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !sat_clr_i) |=> sat_o);  // R7
  AST_SAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_clr_i && !valid_i) |=> !sat_o);  // R8
  AST_UNS_NEG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i && src_i[31]) |=> (result_o[31:0] == 32'h0 && sat_o));  // R3
  AST_SIGNED_FULL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i && imm_i == 5'd31) |=> (result_o == $past(src_i)));  // R5
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && !valid_o && !sat_o));  // R9
endmodule

bind pw_clip pw_clip_chk #(.XLEN(XLEN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .imm_i    (imm_i),
  .src_i    (src_i),
  .sat_clr_i(sat_clr_i),
  .result_o (result_o),
  .valid_o  (valid_o),
  .sat_o    (sat_o)
);

// File: tb/tb_pw_clip.sv
module tb_pw_clip;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned NLANE = XLEN / 32;

  typedef struct {
    logic            vld;
    logic [XLEN-1:0] res;
    logic            sat;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid_i = 1'b0;
  logic            op_i = 1'b0;
  logic [4:0]      imm_i = '0;
  logic [XLEN-1:0] src_i = '0;
  logic            sat_clr_i = 1'b0;
  logic [XLEN-1:0] result_o;
  logic            valid_o;
  logic            sat_o;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic            m_sat = 1'b0;
  logic [XLEN-1:0] m_res = '0;
  bit done = 0;

  always #5 clk = ~clk;

  pw_clip #(.XLEN(XLEN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .imm_i(imm_i), .src_i(src_i), .sat_clr_i(sat_clr_i),
    .result_o(result_o), .valid_o(valid_o), .sat_o(sat_o)
  );

  function automatic logic [32:0] ref_lane(logic uns, int n, logic [31:0] x);
    longint v, hi, lo;
    v  = longint'($signed(x));
    hi = (64'sd1 <<< n) - 1;
    lo = uns ? 64'sd0 : -(64'sd1 <<< n);
    if (v > hi) return {1'b1, hi[31:0]};
    if (v < lo) return {1'b1, lo[31:0]};
    return {1'b0, x};
  endfunction

  task automatic step(logic v, logic op, logic [4:0] n, logic [XLEN-1:0] s,
                      logic clr, string tag);
    exp_t e;
    logic clip = 1'b0;
    logic [32:0] r;
    @(negedge clk);
    valid_i = v; op_i = op; imm_i = n; src_i = s; sat_clr_i = clr;
    if (v) begin
      for (int k = 0; k < NLANE; k++) begin
        r = ref_lane(op, int'(n), s[k*32 +: 32]);
        m_res[k*32 +: 32] = r[31:0];
        clip |= r[32];
      end
    end
    if (v && clip) m_sat = 1'b1;
    else if (clr)  m_sat = 1'b0;
    e.vld = v; e.res = m_res; e.sat = m_sat; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n, logic clr, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 5'd0, '0, clr, tag);
  endtask

  function automatic logic [31:0] near_bound(int n);
    logic [31:0] b;
    int sel = int'($urandom % 6);
    case (sel)
      0: b = 32'(1) << n;
      1: b = (32'(1) << n) - 1;
      2: b = -(32'(1) << n);
      3: b = -(32'(1) << n) - 1;
      default: b = $urandom;
    endcase
    return b + 32'($urandom % 5) - 32'd2;
  endfunction

  // monitor: the entry driven before edge k is compared just after edge k
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (valid_o !== e.vld || result_o !== e.res || sat_o !== e.sat) begin
          errors++;
          $display("FAIL %s: valid=%b res=%h sat=%b exp valid=%b res=%h sat=%b",
                   e.tag, valid_o, result_o, sat_o, e.vld, e.res, e.sat);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;  // R9 reset state
    if (result_o !== '0 || valid_o !== 1'b0 || sat_o !== 1'b0) begin
      errors++;
      $display("FAIL R9: res=%h valid=%b sat=%b exp 0 0 0", result_o, valid_o, sat_o);
    end
    @(negedge clk); rst_n = 1'b1;

    // R5 in-range passes, no flag; signed n=31 never clips
    step(1'b1, 1'b0, 5'd31, 64'h8000_0000_7fff_ffff, 1'b0, "R5");
    step(1'b1, 1'b0, 5'd4, 64'hffff_fff0_0000_000f, 1'b0, "R5");
    step(1'b1, 1'b1, 5'd31, 64'h7fff_ffff_0000_0000, 1'b0, "R5");
    // R6 hold across idle
    idle(2, 1'b0, "R6");
    // R2 signed bounds
    step(1'b1, 1'b0, 5'd4, 64'h0000_0010_0000_0000, 1'b0, "R2");
    step(1'b1, 1'b0, 5'd4, 64'hffff_ffef_0000_0005, 1'b0, "R2");
    step(1'b1, 1'b0, 5'd0, 64'h0000_0001_ffff_fffe, 1'b0, "R2");
    // R7 sticky through idle, R8 clear without op
    idle(3, 1'b0, "R7");
    idle(1, 1'b1, "R8");
    idle(1, 1'b0, "R8");
    // R3 unsigned negative
    step(1'b1, 1'b1, 5'd10, 64'h0000_0005_8000_0000, 1'b0, "R3");
    idle(1, 1'b1, "R8");
    // R4 unsigned upper bound
    step(1'b1, 1'b1, 5'd8, 64'h0000_0100_0000_00ff, 1'b0, "R4");
    // R8 set wins over clear
    step(1'b1, 1'b0, 5'd2, 64'h0000_0004_0000_0000, 1'b1, "R8");
    idle(1, 1'b0, "R8");
    idle(1, 1'b1, "R8");
    // R1 lanes independent: only the upper lane clips
    step(1'b1, 1'b1, 5'd3, 64'h0000_0009_0000_0007, 1'b0, "R1");
    step(1'b1, 1'b1, 5'd3, 64'h0000_0003_ffff_ffff, 1'b1, "R1");

    // random sweep of every bound position, both variants
    for (int n = 0; n < 32; n++) begin
      for (int op = 0; op < 2; op++) begin
        for (int i = 0; i < 24; i++) begin
          logic [XLEN-1:0] s;
          for (int k = 0; k < NLANE; k++) s[k*32 +: 32] = near_bound(n);
          step(1'b1, op[0], 5'(n), s, ($urandom % 4) == 0,
               op == 0 ? "R2" : "R4");
          if (($urandom % 5) == 0) idle(1, ($urandom % 2) == 0, "R7");
        end
      end
    end

    idle(3, 1'b0, "R6");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule